// File: doc/BRIEF.md
# Three-wire synchronous serial port

This block moves one byte at a time, in both directions at once, over three lines: a serial input, a serial output and a shift clock. It can act as a master, generating the shift clock from the system clock with a selectable divide. It can also act as a slave, following an external shift clock that it synchronizes into the system clock domain and edge-detects. A small two-register host interface lets software load and read the shift register, choose the mode, the clock divide and the clock phase, and start a transfer by setting a busy flag. Clearing that flag early cuts the transfer short.

When the busy flag drops, either because eight bits have shifted or because software aborted the transfer, the block raises a one-cycle interrupt pulse. Software then reads back the received byte from the same register it loaded.

Top module: `tws_port`

## Requirements
- R1: Address 0 is the shift register and address 1 is the control register, with div select in bits [1:0], master in bit 2, alternate phase in bit 3 and busy in bit 4; the upper bits read as zero. `rd_data` shows the register selected by `addr` one clock later. After reset every register, `so`, `sck_out` and `irq` are 0.
- R2: Data moves most significant bit first in both directions. `so` is driven from bit 7 of the shift register and `si` enters at bit 0. After a full transfer, address 0 holds the received byte.
- R3: In normal phase (bit 3 = 0), `si` is sampled on the rising shift-clock edge and `so` changes on the falling edge. Bit 7 of a freshly loaded byte appears on `so` before the first edge.
- R4: In alternate phase (bit 3 = 1), `si` is sampled on the falling edge and `so` changes on the rising edge.
- R5: In master mode, the `sck_out` period is 2, 4 or 8 system clocks for div select 00, 01 or 1x. The divider is held cleared and `sck_out` is low whenever busy is 0.
- R6: Writing 1 to the busy bit while idle starts an 8-bit transfer. Busy clears itself on the falling shift-clock edge that ends the eighth clock pulse.
- R7: `irq` is high for exactly one clock, in the cycle in which busy has just fallen, whether busy fell on completion or on an abort.
- R8: Writing 0 to the busy bit during a transfer aborts it. In master mode the abort waits until `sck_out` is low, and no further shift-clock pulse follows. The bits already shifted stay in the shift register.
- R9: In slave mode, `sck_in` passes through a two-flop synchronizer and its edges act in the system clock domain. While busy is 0, `sck_in` edges do not shift the register.
- R10: During a transfer, writes to address 0 are ignored, and writes to address 1 change nothing except an abort.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 1 | Register select for reads and writes (0 data, 1 control) |
| wr_data | input | DATA_W | Host write data |
| rd_data | output | DATA_W | Registered read data for `addr` |
| si | input | 1 | Serial data input |
| sck_in | input | 1 | External shift clock, used in slave mode |
| so | output | 1 | Serial data output |
| sck_out | output | 1 | Generated shift clock, low unless a master transfer runs |
| irq | output | 1 | One-cycle pulse when busy falls |

## Verification
The bound checker watches several rules on every cycle:
- the shift clock stays low while idle, and busy never drops while the clock is high;
- the interrupt pulse lines up one to one with each fall of busy;
- the bit counter never passes eight;
- the shift register holds still during a transfer except on a sample edge;
- the shift register holds still while idle except on a host write.

Other behaviours only the bench scenarios can show: bit order, which edge samples and which launches in each phase, the clock period for each divide select, and the exact bits left behind by an abort that arrives while the clock is high. The bench drives these through a vector table in master mode and directed slave and abort runs.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int CTRL_W     = 5;
  localparam int MASTER_BIT = 2;
  localparam int ALT_BIT    = 3;
  localparam int BUSY_BIT   = 4;
  localparam int DIV_W      = 2;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  typedef struct packed {
    logic             busy;
    logic             alt;
    logic             master;
    logic [DIV_W-1:0] div;
  } ctrl_t;

  // last count of a half period: 00 -> 0, 01 -> 1, 1x -> 3
  function automatic logic [DIV_W-1:0] half_last(input logic [DIV_W-1:0] div);
    return {div[1], div[1] | div[0]};
  endfunction
endpackage

// File: rtl/tws_mclk.sv
module tws_mclk import tws_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [DIV_W-1:0] cnt;
  logic             tc;

  always_comb begin
    tc      = (cnt == half_last(div));
    rise_ev = ~hold & tc & ~sck;
    fall_ev = ~hold & tc & sck;
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (tc) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tws_sync_edge.sv
module tws_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/tws_shifter.sv
module tws_shifter #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [W-1:0]  load_data,
  input  logic          start,
  input  logic          sample_ev,
  input  logic          launch_ev,
  input  logic          si,
  output logic [W-1:0]  shreg,
  output logic [CW-1:0] bitcnt,
  output logic          so
);
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      bitcnt <= '0;
      so     <= 1'b0;
    end else begin
      if (load_en) begin
        shreg <= load_data;
        so    <= load_data[W-1];
      end else if (sample_ev) begin
        shreg  <= {shreg[W-2:0], si};
        bitcnt <= bitcnt + 1'b1;
      end
      if (launch_ev) so <= shreg[W-1];
      if (start) bitcnt <= '0;
    end
  end
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl import tws_pkg::*; #(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [W-1:0]     wr_data,
  input  logic             sck_q,
  input  logic             done_ev,
  input  logic [W-1:0]     shreg,
  output logic             busy,
  output logic             master,
  output logic             alt,
  output logic [DIV_W-1:0] div,
  output logic             abort_now,
  output logic             start,
  output logic             load_en,
  output logic             irq,
  output logic [W-1:0]     rd_data
);
  ctrl_t cfg;
  logic  abort_pend, abort_req, ctrl_wr, busy_d;
  logic  unused_hi;

  assign unused_hi = ^wr_data[W-1:CTRL_W];

  always_comb begin
    ctrl_wr   = wr_en & (addr == ADDR_CTRL);
    load_en   = wr_en & (addr == ADDR_DATA) & ~cfg.busy;
    start     = ctrl_wr & ~cfg.busy & wr_data[BUSY_BIT];
    abort_req = ctrl_wr & cfg.busy & ~wr_data[BUSY_BIT];
    abort_now = cfg.busy & (abort_req | abort_pend) & ~sck_q;
    busy_d    = cfg.busy;
    if (!cfg.busy) begin
      if (start) busy_d = 1'b1;
    end else if (done_ev || abort_now) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg        <= '0;
      abort_pend <= 1'b0;
      irq        <= 1'b0;
      rd_data    <= '0;
    end else begin
      cfg.busy   <= busy_d;
      irq        <= cfg.busy & ~busy_d;
      abort_pend <= cfg.busy & ~abort_now & ~done_ev & (abort_pend | abort_req);
      if (ctrl_wr && !cfg.busy) begin
        cfg.div    <= wr_data[DIV_W-1:0];
        cfg.master <= wr_data[MASTER_BIT];
        cfg.alt    <= wr_data[ALT_BIT];
      end
      if (addr == ADDR_CTRL) rd_data <= W'(cfg);
      else                   rd_data <= shreg;
    end
  end

  assign busy   = cfg.busy;
  assign master = cfg.master;
  assign alt    = cfg.alt;
  assign div    = cfg.div;
endmodule

// File: rtl/tws_port.sv
module tws_port import tws_pkg::*; #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              si,
  input  logic              sck_in,
  output logic              so,
  output logic              sck_out,
  output logic              irq
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic              busy, master, alt, abort_now, start, load_en;
  logic [DIV_W-1:0]  div;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              sck_q, clk_hold;
  logic              m_rise, m_fall, s_rise, s_fall;
  logic              rise_ev, fall_ev, sample_ev, launch_ev, done_ev;
  logic              host_data_wr;

  assign clk_hold     = ~busy | ~master | abort_now;
  assign host_data_wr = wr_en & (addr == ADDR_DATA);

  tws_mclk u_mclk (
    .clk(clk), .rst(rst), .hold(clk_hold), .div(div),
    .sck(sck_q), .rise_ev(m_rise), .fall_ev(m_fall)
  );

  tws_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(sck_in), .rise(s_rise), .fall(s_fall)
  );

  always_comb begin
    if (master) begin
      rise_ev = m_rise;
      fall_ev = m_fall;
    end else begin
      rise_ev = s_rise & busy & ~abort_now;
      fall_ev = s_fall & busy & ~abort_now;
    end
    sample_ev = alt ? fall_ev : rise_ev;
    launch_ev = alt ? rise_ev : fall_ev;
    done_ev   = fall_ev & ((bitcnt + CNT_W'(alt)) == CNT_W'(DATA_W));
  end

  tws_shifter #(.W(DATA_W), .CW(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .load_en(load_en), .load_data(wr_data),
    .start(start), .sample_ev(sample_ev), .launch_ev(launch_ev),
    .si(si), .shreg(shreg), .bitcnt(bitcnt), .so(so)
  );

  tws_ctrl #(.W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .sck_q(sck_q), .done_ev(done_ev), .shreg(shreg),
    .busy(busy), .master(master), .alt(alt), .div(div),
    .abort_now(abort_now), .start(start), .load_en(load_en),
    .irq(irq), .rd_data(rd_data)
  );

  assign sck_out = sck_q;
endmodule

// File: rtl/tws_port_chk.sv
module tws_port_chk #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          sck_out,
  input logic          irq,
  input logic [CW-1:0] bitcnt,
  input logic [W-1:0]  shreg,
  input logic          sample_ev,
  input logic          data_wr
);
  p_sck_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck_out);

  p_no_narrow_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !sck_out);

  p_irq_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> irq);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $fell(busy));

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_bitcnt_max_r6: assert property (@(posedge clk) disable iff (rst)
    bitcnt <= CW'(W));

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && !sample_ev) |=> $stable(shreg));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !data_wr) |=> $stable(shreg));
endmodule

bind tws_port tws_port_chk #(.W(DATA_W), .CW(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .sck_out(sck_out), .irq(irq),
  .bitcnt(bitcnt), .shreg(shreg), .sample_ev(sample_ev), .data_wr(host_data_wr)
);

// File: tb/test_tws_port.sv
`timescale 1ns/1ps
module test_tws_port;
  logic       clk = 1'b0, rst = 1'b1, wr_en = 1'b0, addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       si = 1'b0, sck_in = 1'b0;
  logic       so, sck_out, irq;

  always #2 clk = ~clk;

  tws_port i_tws_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .si(si), .sck_in(sck_in), .so(so),
    .sck_out(sck_out), .irq(irq)
  );

  int total = 0, fails = 0;
  int cyc = 0, rises = 0, falls = 0, irq_cnt = 0, last_rise = 0, period = 0, si_idx = 0;
  logic       mon_alt = 1'b0, sck_prev = 1'b0;
  logic [7:0] rx_pat = '0, so_cap = '0, rv;

  // {cfg: bit2 alt, bits1:0 div} , tx byte, rx byte
  localparam logic [23:0] VEC [0:5] = '{
    24'h00_A5_3C, 24'h01_81_7E, 24'h02_F0_0F,
    24'h03_5A_C3, 24'h04_69_96, 24'h06_FF_00
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // monitor of the master clock: external device model, sampled at negedge
  always @(negedge clk) begin
    cyc++;
    if (sck_out && !sck_prev) begin
      if (rises > 0) period = cyc - last_rise;
      last_rise = cyc;
      rises++;
      if (!mon_alt) so_cap = {so_cap[6:0], so};
      else begin
        if (si_idx < 8) si = rx_pat[7 - si_idx];
        si_idx++;
      end
    end
    if (!sck_out && sck_prev) begin
      falls++;
      if (!mon_alt) begin
        si_idx++;
        if (si_idx < 8) si = rx_pat[7 - si_idx];
      end else so_cap = {so_cap[6:0], so};
    end
    if (irq) irq_cnt++;
    sck_prev = sck_out;
  end

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a;
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    for (int n = 0; n < 4000; n++) begin
      rd(1'b1, c);
      if (!c[4]) return;
    end
    chk("R6 busy never cleared", 32'd1, 32'd0);
  endtask

  task automatic mon_reset(input logic a, input logic [7:0] rx);
    mon_alt = a; rx_pat = rx; so_cap = '0;
    rises = 0; falls = 0; irq_cnt = 0; period = 0; si_idx = 0;
    si = a ? 1'b0 : rx[7];
  endtask

  task automatic run_master(input logic [23:0] v);
    logic [1:0] dv = v[17:16];
    logic       a  = v[18];
    int         exp_p = (dv == 2'b00) ? 2 : (dv == 2'b01) ? 4 : 8;
    mon_reset(a, v[7:0]);
    wr(1'b0, v[15:8]);
    chk("R3 MSB on so after load", {31'd0, so}, {31'd0, v[15]});
    wr(1'b1, {3'b000, 1'b1, a, 1'b1, dv});
    wait_idle();
    rd(1'b0, rv);
    chk(a ? "R4 R2 master rx alt" : "R3 R2 master rx normal", {24'd0, rv}, {24'd0, v[7:0]});
    chk(a ? "R4 so order alt" : "R3 so order normal", {24'd0, so_cap}, {24'd0, v[15:8]});
    chk("R5 sck period", period, exp_p);
    chk("R6 eight pulses", rises, 8);
    chk("R7 one irq", irq_cnt, 1);
    rd(1'b1, rv);
    chk("R1 ctrl readback", {24'd0, rv}, {24'd0, 4'b0000, a, 1'b1, dv});
    chk("R5 sck idle low", {31'd0, sck_out}, 32'd0);
  endtask

  task automatic run_slave(input logic a, input logic [7:0] tx, input logic [7:0] rx);
    mon_reset(a, rx);
    si = 1'b0;
    wr(1'b0, tx);
    wr(1'b1, {3'b000, 1'b1, a, 1'b0, 2'b00});
    for (int i = 0; i < 8; i++) begin
      if (!a) begin so_cap = {so_cap[6:0], so}; si = rx[7 - i]; end
      sck_in = 1'b1;
      repeat (6) @(negedge clk);
      if (a) begin so_cap = {so_cap[6:0], so}; si = rx[7 - i]; end
      sck_in = 1'b0;
      repeat (6) @(negedge clk);
    end
    rd(1'b1, rv);
    chk("R9 R6 slave busy cleared", {24'd0, rv}, {24'd0, 4'b0000, a, 3'b000});
    rd(1'b0, rv);
    chk("R9 R2 slave rx", {24'd0, rv}, {24'd0, rx});
    chk("R9 slave so order", {24'd0, so_cap}, {24'd0, tx});
    chk("R7 slave irq", irq_cnt, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 so reset", {31'd0, so}, 32'd0);
    chk("R1 sck_out reset", {31'd0, sck_out}, 32'd0);
    chk("R1 irq reset", {31'd0, irq}, 32'd0);
    rd(1'b0, rv); chk("R1 data reset", {24'd0, rv}, 32'd0);
    rd(1'b1, rv); chk("R1 ctrl reset", {24'd0, rv}, 32'd0);

    for (int k = 0; k < 6; k++) run_master(VEC[k]);

    // R10: writes during a transfer are ignored
    mon_reset(1'b0, 8'h4B);
    wr(1'b0, 8'hC3);
    wr(1'b1, 8'h16);
    repeat (6) @(negedge clk);
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h1D);
    wait_idle();
    rd(1'b0, rv); chk("R10 data write ignored", {24'd0, rv}, 32'h4B);
    rd(1'b1, rv); chk("R10 ctrl fields frozen", {24'd0, rv}, 32'h06);
    chk("R10 so unaffected", {24'd0, so_cap}, 32'hC3);

    // R8: abort while sck high, div 8, normal phase
    mon_reset(1'b0, 8'hFF);
    wr(1'b0, 8'hA5);
    wr(1'b1, 8'h16);
    while (rises < 3) @(negedge clk);
    chk("R8 sck high at abort", {31'd0, sck_out}, 32'd1);
    wr(1'b1, 8'h06);
    repeat (20) @(negedge clk);
    chk("R8 no pulse after abort", rises, 3);
    chk("R7 irq on abort", irq_cnt, 1);
    rd(1'b1, rv); chk("R8 busy cleared", {24'd0, rv}, 32'h06);
    rd(1'b0, rv); chk("R8 partial bits kept", {24'd0, rv}, 32'h2F);

    // R9: slave ignores sck_in while idle
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h77);
    si = 1'b0;
    for (int i = 0; i < 4; i++) begin
      sck_in = 1'b1; repeat (6) @(negedge clk);
      sck_in = 1'b0; repeat (6) @(negedge clk);
    end
    rd(1'b0, rv); chk("R9 idle slave no shift", {24'd0, rv}, 32'h77);

    run_slave(1'b0, 8'h3C, 8'hC9);
    run_slave(1'b1, 8'h96, 8'h5A);

    finish_run();
  end
endmodule